// File: doc/BRIEF.md
# Bidirectional Register-Mapped Message Mailbox

This block passes messages between an application processor and an I/O processor. It holds two independent queues. The outbound queue carries messages from the application side to the I/O side, and the inbound queue carries them the other way. Each message has a 64-bit first word and a 32-bit second word. The sender stages the first word, and its write of the second word pushes both words as one entry. The receiver may look at the head entry without removing it. Its read of the second word removes the entry and also returns live pointer and occupancy fields.

Both processors see one register map, presented as two identical register ports. The application port wins any same-cycle conflict on a queue. A small interrupt unit watches four conditions: each queue being empty and each queue holding data. Each condition latches a sticky cause bit. Two level outputs, one for empty events and one for data events, assert while an enabled cause is latched. A cause clears only through a write-one-to-clear acknowledge. If its condition is still present, the cause latches again on the cycle after the acknowledge.

Top module: `mbox_top`

## Requirements
- R1: After reset both queues are empty, the interrupt enable register reads 0, and both interrupt outputs are low.
- R2: Each port has its own staging register per queue. A write to send word 0 (base+0x10) only stages. A write to send word 1 (base+0x18) pushes {staged word 0, wdata[31:0]} as one entry. Entries leave in the order they were pushed. The outbound base is 0x50 and the inbound base is 0x80.
- R3: A queue holds 16 entries. A push while full is dropped and sets a sticky overflow flag at control bit 18. A control write with wdata[18]=1 clears the flag.
- R4: A read of receive word 1 (base+0x28) removes the head entry. A read of receive word 0 (base+0x20) returns the head's first word and removes nothing. A read of an empty queue returns a zero payload and leaves the pointers unchanged.
- R5: The receive word 1 read returns the following fields, all taken from the state before the removal:
  - bits 31:0: the head's second word;
  - bits 43:40: the write pointer;
  - bits 47:44: the read pointer;
  - bits 51:48: the free slots, saturated at 15;
  - bits 56:52: the occupancy, from 0 to 16;
  - all other bits: zero.
- R6: The control register (base+0x00) reads bit 16 = full and bit 17 = empty. All other bits read zero, apart from bit 18 (R3).
- R7: The cause bits, read at 0x4C, are bit 0 = outbound empty, bit 1 = outbound holds data, bit 2 = inbound empty and bit 3 = inbound holds data. A cause sets on the edge after its condition is seen, and it stays set until acknowledged.
- R8: Writing 1s to 0x4C clears those causes on that edge. A cause whose condition still holds sets again on the following edge.
- R9: The enable register at 0x48 is 4 bits, readable and writable. irq_empty is the OR of (cause AND enable) over bits 0 and 2. irq_data is the same over bits 1 and 3.
- R10: When both ports push to one queue in the same cycle, only the application port's entry is taken, and the overflow flag is not set. When both ports read receive word 1 of one queue in the same cycle, exactly one entry is removed and both ports return the same data. When both ports write the enable register in the same cycle, the application port's value is kept.
- R11: The following accesses change no state:
  - writes to receive registers;
  - reads of send registers;
  - accesses to unmapped addresses.

  The send registers and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ap_req | input | 1 | Application port access strobe |
| ap_we | input | 1 | Application port write (1) or read (0) |
| ap_addr | input | 8 | Application port byte address |
| ap_wdata | input | 64 | Application port write data |
| ap_rdata | output | 64 | Application port read data, same cycle |
| io_req | input | 1 | I/O port access strobe |
| io_we | input | 1 | I/O port write (1) or read (0) |
| io_addr | input | 8 | I/O port byte address |
| io_wdata | input | 64 | I/O port write data |
| io_rdata | output | 64 | I/O port read data, same cycle |
| irq_empty | output | 1 | Level interrupt for enabled empty causes |
| irq_data | output | 1 | Level interrupt for enabled data causes |

## Verification
The bound checker watches a set of properties on every cycle:
- occupancy never exceeds the depth, and full and empty are never set together;
- a push into a full queue leaves the occupancy unchanged;
- a removal from an empty queue leaves the read pointer unchanged;
- an acknowledged cause is low on the next cycle, and an unacknowledged cause stays high;
- each interrupt output needs an enabled, latched cause behind it.

Some behaviours only the bench's scenarios can show:
- message ordering and payload integrity;
- the separate staging registers of each port;
- the word 1 field packing;
- the one-cycle dip and re-latch after an acknowledge;
- the port priority rules.

The bench checks these against a reference model that is stepped at every clock edge.

// File: rtl/mbox_pkg.sv
// Shared types, register offsets and read-data packing for the mailbox.
package mbox_pkg;

    localparam int NFIFO  = 2;
    localparam int NCAUSE = 4;
    localparam int PTR_FW = 4;
    localparam int CNT_FW = 5;

    typedef struct packed {
        logic [63:0] w0;
        logic [31:0] w1;
    } msg_t;

    typedef struct packed {
        msg_t              head;
        logic              full;
        logic              empty;
        logic              ovf;
        logic [PTR_FW-1:0] wptr;
        logic [PTR_FW-1:0] rptr;
        logic [CNT_FW-1:0] cnt;
        logic [3:0]        free;
    } fifo_view_t;

    localparam logic [7:0] ADDR_IRQ_EN  = 8'h48;
    localparam logic [7:0] ADDR_IRQ_ACK = 8'h4C;
    localparam logic [7:0] OFS_CTL      = 8'h00;
    localparam logic [7:0] OFS_SEND0    = 8'h10;
    localparam logic [7:0] OFS_SEND1    = 8'h18;
    localparam logic [7:0] OFS_RECV0    = 8'h20;
    localparam logic [7:0] OFS_RECV1    = 8'h28;

    localparam int BIT_FULL  = 16;
    localparam int BIT_EMPTY = 17;
    localparam int BIT_OVF   = 18;

    localparam logic [NCAUSE-1:0] EMPTY_CAUSES = 4'b0101;
    localparam logic [NCAUSE-1:0] DATA_CAUSES  = 4'b1010;

    // Queue 0 is outbound (application to I/O), queue 1 is inbound.
    function automatic logic [7:0] fifo_base(input int f);
        return (f == 0) ? 8'h50 : 8'h80;
    endfunction

    function automatic logic [63:0] pack_ctl(input fifo_view_t v);
        logic [63:0] r;
        r            = '0;
        r[BIT_FULL]  = v.full;
        r[BIT_EMPTY] = v.empty;
        r[BIT_OVF]   = v.ovf;
        return r;
    endfunction

    function automatic logic [63:0] pack_w1(input fifo_view_t v);
        return {7'd0, v.cnt, v.free, v.rptr, v.wptr, 8'd0, v.head.w1};
    endfunction

endpackage

// File: rtl/mbox_fifo.sv
// One message queue of DEPTH 96-bit entries.
// Assumes DEPTH <= 16 so that the pointers and the count fit the reported fields.
// A push while full is dropped and latches the overflow flag; a pop while empty is ignored.
module mbox_fifo
    import mbox_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  msg_t       push_msg,
    input  logic       pop,
    input  logic       ovf_clr,
    output fifo_view_t view
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    msg_t          mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          ovf;
    logic          full, empty, do_push, do_pop;
    int            free_i;

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;

    // Store an accepted entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_msg;
    end

    // Advance the pointers with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
        end
    end

    // Track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Sticky overflow: a clear is applied first, a new drop sets it again.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else        ovf <= (ovf & ~ovf_clr) | (push & full);
    end

    // Free slots, saturated to the 4-bit field.
    always_comb begin
        free_i = DEPTH - int'(cnt);
        if (free_i > 15) free_i = 15;
    end

    // Present the live state and the head entry (zero when empty).
    always_comb begin
        view.head  = empty ? '0 : mem[rp];
        view.full  = full;
        view.empty = empty;
        view.ovf   = ovf;
        view.wptr  = PTR_FW'(wp);
        view.rptr  = PTR_FW'(rp);
        view.cnt   = CNT_FW'(cnt);
        view.free  = 4'(free_i);
    end

endmodule

// File: rtl/mbox_irq.sv
// Interrupt unit: one sticky cause per condition, an enable mask, and two level outputs.
// Assumes the ack is one cycle wide per write; an ack clears a cause for one edge,
// after which the live condition re-latches it.
module mbox_irq
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] cond,
    input  logic [NCAUSE-1:0] ack,
    input  logic              en_we,
    input  logic [NCAUSE-1:0] en_wdata,
    output logic [NCAUSE-1:0] en,
    output logic [NCAUSE-1:0] sticky,
    output logic              irq_empty,
    output logic              irq_data
);
    logic [NCAUSE-1:0] active;

    // Hold the enable mask written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_we) en <= en_wdata;
    end

    for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
        // Latch the condition; the acknowledge wins for one edge.
        always_ff @(posedge clk) begin
            if (!rst_n)      sticky[i] <= 1'b0;
            else if (ack[i]) sticky[i] <= 1'b0;
            else if (cond[i]) sticky[i] <= 1'b1;
        end
    end

    assign active    = sticky & en;
    assign irq_empty = |(active & EMPTY_CAUSES);
    assign irq_data  = |(active & DATA_CAUSES);

endmodule

// File: rtl/mbox_regport.sv
// One register port: decodes accesses, keeps this port's staged first words,
// and returns read data in the same cycle.
// Assumes one access per cycle on this port.
module mbox_regport
    import mbox_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic                         we,
    input  logic [7:0]                   addr,
    input  logic [63:0]                  wdata,
    input  fifo_view_t [NFIFO-1:0]       view,
    input  logic [NCAUSE-1:0]            en,
    input  logic [NCAUSE-1:0]            sticky,
    output logic [63:0]                  rdata,
    output logic [NFIFO-1:0]             push,
    output msg_t [NFIFO-1:0]             push_msg,
    output logic [NFIFO-1:0]             pop,
    output logic [NFIFO-1:0]             ovf_clr,
    output logic                         en_we,
    output logic [NCAUSE-1:0]            en_wdata,
    output logic [NCAUSE-1:0]            ack
);
    logic wr, rd;
    logic [NFIFO-1:0][63:0] stage_q;

    assign wr = req & we;
    assign rd = req & ~we;

    for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
        localparam logic [7:0] BASE = fifo_base(f);

        // Stage the first word of the next message for this queue.
        always_ff @(posedge clk) begin
            if (!rst_n)                             stage_q[f] <= '0;
            else if (wr && addr == BASE + OFS_SEND0) stage_q[f] <= wdata;
        end

        assign push[f]     = wr && (addr == BASE + OFS_SEND1);
        assign push_msg[f] = {stage_q[f], wdata[31:0]};
        assign pop[f]      = rd && (addr == BASE + OFS_RECV1);
        assign ovf_clr[f]  = wr && (addr == BASE + OFS_CTL) && wdata[BIT_OVF];
    end

    assign en_we    = wr && (addr == ADDR_IRQ_EN);
    assign en_wdata = wdata[NCAUSE-1:0];
    assign ack      = (wr && addr == ADDR_IRQ_ACK) ? wdata[NCAUSE-1:0] : '0;

    // Select read data from the live state; non-reads and unmapped addresses give zero.
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == ADDR_IRQ_EN)  rdata = {{(64-NCAUSE){1'b0}}, en};
            if (addr == ADDR_IRQ_ACK) rdata = {{(64-NCAUSE){1'b0}}, sticky};
            for (int f = 0; f < NFIFO; f++) begin
                if (addr == fifo_base(f) + OFS_CTL)   rdata = pack_ctl(view[f]);
                if (addr == fifo_base(f) + OFS_RECV0) rdata = view[f].head.w0;
                if (addr == fifo_base(f) + OFS_RECV1) rdata = pack_w1(view[f]);
            end
        end
    end

endmodule

// File: rtl/mbox_top.sv
// Two-queue mailbox with two identical register ports and an interrupt unit.
// The application port has priority when both ports push, pop or write the enable
// register of the same target in one cycle. Assumes DEPTH <= 16.
module mbox_top
    import mbox_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ap_req,
    input  logic        ap_we,
    input  logic [7:0]  ap_addr,
    input  logic [63:0] ap_wdata,
    output logic [63:0] ap_rdata,
    input  logic        io_req,
    input  logic        io_we,
    input  logic [7:0]  io_addr,
    input  logic [63:0] io_wdata,
    output logic [63:0] io_rdata,
    output logic        irq_empty,
    output logic        irq_data
);
    fifo_view_t [NFIFO-1:0] view;
    logic [NCAUSE-1:0] en, sticky, cond, ack;
    logic              en_we;
    logic [NCAUSE-1:0] en_wdata;

    logic [NFIFO-1:0]  a_push, a_pop, a_clr, i_push, i_pop, i_clr;
    msg_t [NFIFO-1:0]  a_msg, i_msg;
    logic              a_en_we, i_en_we;
    logic [NCAUSE-1:0] a_en_wd, i_en_wd, a_ack, i_ack;

    logic [NFIFO-1:0]             push_v, pop_v, full_v, empty_v;
    logic [NFIFO-1:0][CNT_FW-1:0] cnt_v;
    logic [NFIFO-1:0][PTR_FW-1:0] rptr_v;

    mbox_regport i_port_ap (
        .clk(clk), .rst_n(rst_n), .req(ap_req), .we(ap_we), .addr(ap_addr),
        .wdata(ap_wdata), .view(view), .en(en), .sticky(sticky), .rdata(ap_rdata),
        .push(a_push), .push_msg(a_msg), .pop(a_pop), .ovf_clr(a_clr),
        .en_we(a_en_we), .en_wdata(a_en_wd), .ack(a_ack)
    );

    mbox_regport i_port_io (
        .clk(clk), .rst_n(rst_n), .req(io_req), .we(io_we), .addr(io_addr),
        .wdata(io_wdata), .view(view), .en(en), .sticky(sticky), .rdata(io_rdata),
        .push(i_push), .push_msg(i_msg), .pop(i_pop), .ovf_clr(i_clr),
        .en_we(i_en_we), .en_wdata(i_en_wd), .ack(i_ack)
    );

    for (genvar f = 0; f < NFIFO; f++) begin : g_q
        msg_t sel_msg;
        assign push_v[f]  = a_push[f] | i_push[f];
        assign pop_v[f]   = a_pop[f] | i_pop[f];
        assign sel_msg    = a_push[f] ? a_msg[f] : i_msg[f];
        assign full_v[f]  = view[f].full;
        assign empty_v[f] = view[f].empty;
        assign cnt_v[f]   = view[f].cnt;
        assign rptr_v[f]  = view[f].rptr;

        mbox_fifo #(.DEPTH(DEPTH)) i_fifo (
            .clk(clk), .rst_n(rst_n), .push(push_v[f]), .push_msg(sel_msg),
            .pop(pop_v[f]), .ovf_clr(a_clr[f] | i_clr[f]), .view(view[f])
        );
    end

    assign cond     = {~view[1].empty, view[1].empty, ~view[0].empty, view[0].empty};
    assign ack      = a_ack | i_ack;
    assign en_we    = a_en_we | i_en_we;
    assign en_wdata = a_en_we ? a_en_wd : i_en_wd;

    mbox_irq i_irq (
        .clk(clk), .rst_n(rst_n), .cond(cond), .ack(ack), .en_we(en_we),
        .en_wdata(en_wdata), .en(en), .sticky(sticky),
        .irq_empty(irq_empty), .irq_data(irq_data)
    );

endmodule

// File: rtl/mbox_checker.sv
// Cycle-level properties of the mailbox, bound to mbox_top.
module mbox_checker
    import mbox_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NFIFO-1:0]             push_v,
    input logic [NFIFO-1:0]             pop_v,
    input logic [NFIFO-1:0]             full_v,
    input logic [NFIFO-1:0]             empty_v,
    input logic [NFIFO-1:0][CNT_FW-1:0] cnt_v,
    input logic [NFIFO-1:0][PTR_FW-1:0] rptr_v,
    input logic [NCAUSE-1:0]            ack,
    input logic [NCAUSE-1:0]            sticky,
    input logic [NCAUSE-1:0]            en,
    input logic                         irq_empty,
    input logic                         irq_data
);
    for (genvar f = 0; f < NFIFO; f++) begin : g_f
        a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
            int'(cnt_v[f]) <= DEPTH);
        a_r6_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
            !(full_v[f] && empty_v[f]));
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            full_v[f] && push_v[f] && !pop_v[f] |=> $stable(cnt_v[f]));
        a_r4_empty_pop_still: assert property (@(posedge clk) disable iff (!rst_n)
            empty_v[f] && pop_v[f] && !push_v[f] |=> $stable(rptr_v[f]) && empty_v[f]);
    end

    for (genvar i = 0; i < NCAUSE; i++) begin : g_c
        a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            ack[i] |=> !sticky[i]);
        a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
            sticky[i] && !ack[i] |=> sticky[i]);
    end

    a_r9_empty_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> |(sticky & en & EMPTY_CAUSES));
    a_r9_data_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq_data |-> |(sticky & en & DATA_CAUSES));

endmodule

bind mbox_top mbox_checker #(.DEPTH(DEPTH)) i_mbox_checker (
    .clk(clk), .rst_n(rst_n), .push_v(push_v), .pop_v(pop_v), .full_v(full_v),
    .empty_v(empty_v), .cnt_v(cnt_v), .rptr_v(rptr_v), .ack(ack), .sticky(sticky),
    .en(en), .irq_empty(irq_empty), .irq_data(irq_data)
);

// File: tb/test_mbox_top.sv
`timescale 1ns/1ps
module test_mbox_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ap_req = 0, ap_we = 0, io_req = 0, io_we = 0;
    logic [7:0]  ap_addr = 0, io_addr = 0;
    logic [63:0] ap_wdata = 0, io_wdata = 0;
    logic [63:0] ap_rdata, io_rdata;
    logic        irq_empty, irq_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mbox_top i_mbox_top (
        .clk(clk), .rst_n(rst_n),
        .ap_req(ap_req), .ap_we(ap_we), .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_rdata(ap_rdata),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .irq_empty(irq_empty), .irq_data(irq_data)
    );

    // ---------------- reference model ----------------
    logic [95:0] mq0[$], mq1[$];
    int          mwp[2], mrp[2];
    logic        movf[2];
    logic [63:0] mst[2][2];
    logic [3:0]  msticky, men;
    logic [3:0]  m_c, m_ak;

    function automatic logic [7:0] base(input int f);
        return (f == 0) ? 8'h50 : 8'h80;
    endfunction

    function automatic int msize(input int f);
        return (f == 0) ? mq0.size() : mq1.size();
    endfunction

    function automatic logic [95:0] mhead(input int f);
        if (msize(f) == 0) return '0;
        return (f == 0) ? mq0[0] : mq1[0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq0.delete(); mq1.delete();
            for (int f = 0; f < 2; f++) begin
                mwp[f] = 0; mrp[f] = 0; movf[f] = 0;
                mst[0][f] = '0; mst[1][f] = '0;
            end
            msticky = '0; men = '0;
        end else begin
            m_c = {msize(1) != 0, msize(1) == 0, msize(0) != 0, msize(0) == 0};
            for (int f = 0; f < 2; f++) begin
                int  sz;
                bit  pa, pi, rp, clr;
                sz  = msize(f);
                pa  = ap_req && ap_we && ap_addr == base(f) + 8'h18;
                pi  = io_req && io_we && io_addr == base(f) + 8'h18;
                rp  = (ap_req && !ap_we && ap_addr == base(f) + 8'h28) ||
                      (io_req && !io_we && io_addr == base(f) + 8'h28);
                clr = (ap_req && ap_we && ap_addr == base(f) && ap_wdata[18]) ||
                      (io_req && io_we && io_addr == base(f) && io_wdata[18]);
                if (rp && sz > 0) begin
                    if (f == 0) void'(mq0.pop_front()); else void'(mq1.pop_front());
                    mrp[f] = (mrp[f] + 1) % 16;
                end
                if ((pa || pi) && sz < 16) begin
                    logic [95:0] e;
                    e = pa ? {mst[0][f], ap_wdata[31:0]} : {mst[1][f], io_wdata[31:0]};
                    if (f == 0) mq0.push_back(e); else mq1.push_back(e);
                    mwp[f] = (mwp[f] + 1) % 16;
                end
                movf[f] = (movf[f] && !clr) || ((pa || pi) && sz == 16);
                if (ap_req && ap_we && ap_addr == base(f) + 8'h10) mst[0][f] = ap_wdata;
                if (io_req && io_we && io_addr == base(f) + 8'h10) mst[1][f] = io_wdata;
            end
            m_ak = ((ap_req && ap_we && ap_addr == 8'h4C) ? ap_wdata[3:0] : 4'h0) |
                   ((io_req && io_we && io_addr == 8'h4C) ? io_wdata[3:0] : 4'h0);
            if (ap_req && ap_we && ap_addr == 8'h48)      men = ap_wdata[3:0];
            else if (io_req && io_we && io_addr == 8'h48) men = io_wdata[3:0];
            for (int i = 0; i < 4; i++) msticky[i] = m_ak[i] ? 1'b0 : (msticky[i] | m_c[i]);
        end
    end

    function automatic logic [63:0] exp_rd(input logic [7:0] ad);
        logic [63:0] r;
        r = '0;
        if (ad == 8'h48) r = {60'd0, men};
        if (ad == 8'h4C) r = {60'd0, msticky};
        for (int f = 0; f < 2; f++) begin
            int sz, fr;
            logic [95:0] h;
            sz = msize(f);
            h  = mhead(f);
            fr = 16 - sz;
            if (fr > 15) fr = 15;
            if (ad == base(f)) begin
                r[16] = (sz == 16); r[17] = (sz == 0); r[18] = movf[f];
            end
            if (ad == base(f) + 8'h20) r = h[95:32];
            if (ad == base(f) + 8'h28)
                r = {7'd0, 5'(sz), 4'(fr), 4'(mrp[f]), 4'(mwp[f]), 8'd0, h[31:0]};
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] ad);
        if (ad == 8'h48) return "R9 enable";
        if (ad == 8'h4C) return "R7 causes";
        if (ad == 8'h50 || ad == 8'h80) return "R6 control";
        if (ad == 8'h70 || ad == 8'hA0) return "R4 recv0";
        if (ad == 8'h78 || ad == 8'hA8) return "R5 recv1";
        return "R11 other";
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_irq();
        check("R9 irq_empty", {63'd0, irq_empty}, {63'd0, |(msticky & men & 4'b0101)});
        check("R9 irq_data",  {63'd0, irq_data},  {63'd0, |(msticky & men & 4'b1010)});
    endtask

    task automatic release_bus();
        ap_req = 0; ap_we = 0; io_req = 0; io_we = 0;
    endtask

    task automatic dual(input bit ua, input bit wa, input logic [7:0] ada, input logic [63:0] da,
                        input bit ui, input bit wi, input logic [7:0] adi, input logic [63:0] di,
                        output logic [63:0] ra, output logic [63:0] ri);
        @(negedge clk);
        ap_req = ua; ap_we = wa; ap_addr = ada; ap_wdata = da;
        io_req = ui; io_we = wi; io_addr = adi; io_wdata = di;
        #1;
        ra = ap_rdata; ri = io_rdata;
        if (ua && !wa) check(tag_of(ada), ra, exp_rd(ada));
        if (ui && !wi) check(tag_of(adi), ri, exp_rd(adi));
        check_irq();
        @(posedge clk);
        #1;
        release_bus();
    endtask

    task automatic op(input bit port, input bit w, input logic [7:0] ad, input logic [63:0] d,
                      output logic [63:0] rd);
        logic [63:0] ra, ri;
        if (!port) dual(1, w, ad, d, 0, 0, 8'h00, '0, ra, ri);
        else       dual(0, 0, 8'h00, '0, 1, w, ad, d, ra, ri);
        rd = port ? ri : ra;
    endtask

    function automatic logic [7:0] pick_addr(input int n);
        case (n)
            0: return 8'h48;  1: return 8'h4C;  2: return 8'h50;  3: return 8'h60;
            4: return 8'h68;  5: return 8'h70;  6: return 8'h78;  7: return 8'h80;
            8: return 8'h90;  9: return 8'h98;  10: return 8'hA0; 11: return 8'hA8;
            12: return 8'h00; default: return 8'h58;
        endcase
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [63:0] rd, ra, ri;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1 irq_empty low", {63'd0, irq_empty}, 64'd0);
        check("R1 irq_data low",  {63'd0, irq_data},  64'd0);
        op(0, 0, 8'h50, '0, rd); check("R1 outbound empty", rd, 64'h0000_0000_0002_0000);
        op(1, 0, 8'h80, '0, rd); check("R1 inbound empty",  rd, 64'h0000_0000_0002_0000);
        op(0, 0, 8'h48, '0, rd); check("R1 enable zero",    rd, 64'd0);

        // R2/R4/R5: stage, push, peek, pop
        op(0, 1, 8'h60, 64'h0123_4567_89AB_CDEF, rd);
        op(0, 0, 8'h80, '0, rd); check("R2 staging alone no push", rd[17], 1'b1);
        op(0, 0, 8'h50, '0, rd); check("R2 staging alone no push out", rd[17], 1'b1);
        op(0, 1, 8'h68, 64'hFFFF_FFFF_AAAA_0001, rd);
        op(1, 0, 8'h70, '0, rd); check("R4 peek word0", rd, 64'h0123_4567_89AB_CDEF);
        op(1, 0, 8'h70, '0, rd); check("R4 peek twice no pop", rd, 64'h0123_4567_89AB_CDEF);
        op(1, 0, 8'h78, '0, rd);
        check("R5 word1 fields", rd, {7'd0, 5'd1, 4'd15, 4'd0, 4'd1, 8'd0, 32'hAAAA_0001});
        op(1, 0, 8'h78, '0, rd);
        check("R4 empty read zero", rd, {7'd0, 5'd0, 4'd15, 4'd1, 4'd1, 8'd0, 32'd0});
        op(1, 0, 8'h78, '0, rd);
        check("R4 empty read pointers still", rd[47:40], 8'h11);

        // R2: per-port staging on the inbound queue
        op(1, 1, 8'h90, 64'h1111_1111_1111_1111, rd);
        op(0, 1, 8'h90, 64'h2222_2222_2222_2222, rd);
        op(1, 1, 8'h98, 64'h0000_0000_0000_0033, rd);
        op(0, 0, 8'hA0, '0, rd); check("R2 own staging word", rd, 64'h1111_1111_1111_1111);
        op(0, 0, 8'hA8, '0, rd);

        // R3: fill past full, overflow, clear
        for (int k = 0; k < 17; k++) begin
            op(0, 1, 8'h60, 64'(k), rd);
            op(0, 1, 8'h68, 64'(k + 100), rd);
        end
        op(1, 0, 8'h50, '0, rd); check("R3 full and overflow", rd, 64'h0000_0000_0005_0000);
        op(1, 0, 8'h78, '0, rd); check("R3 count 16 free 0", rd[56:48], {5'd16, 4'd0});
        check("R3 first entry kept", rd[31:0], 32'd100);
        op(1, 1, 8'h50, 64'h0000_0000_0004_0000, rd);
        op(1, 0, 8'h50, '0, rd); check("R3 overflow cleared", rd[18], 1'b0);
        for (int k = 1; k < 16; k++) begin
            op(1, 0, 8'h78, '0, rd); check("R2 order", rd[31:0], 32'(k + 100));
        end

        // R8/R9: enable, acknowledge with condition held
        op(0, 1, 8'h48, 64'hF, rd);
        op(0, 0, 8'h48, '0, rd); check("R9 enable readback", rd, 64'hF);
        check("R9 irq_empty on", {63'd0, irq_empty}, 64'd1);
        op(0, 1, 8'h4C, 64'hF, rd);
        op(0, 0, 8'h4C, '0, rd); check("R8 cleared for one cycle", rd, 64'h0);
        op(0, 0, 8'h4C, '0, rd); check("R8 relatch empties", rd, 64'h5);
        op(0, 1, 8'h48, 64'h0, rd);
        op(0, 0, 8'h4C, '0, rd);
        check("R9 masked irq", {62'd0, irq_data, irq_empty}, 64'd0);

        // R7: data cause stays after queue drains until acknowledged
        op(1, 1, 8'h68, 64'h55, rd);
        op(0, 0, 8'h78, '0, rd);
        op(0, 0, 8'h4C, '0, rd); check("R7 data cause sticky", rd[1], 1'b1);
        op(0, 1, 8'h4C, 64'h2, rd);
        op(0, 0, 8'h4C, '0, rd); check("R7 data cause gone", rd[1], 1'b0);

        // R10: simultaneous push, pop and enable write
        dual(1, 1, 8'h90, 64'hA, 1, 1, 8'h90, 64'hB, ra, ri);
        dual(1, 1, 8'h98, 64'h1, 1, 1, 8'h98, 64'h2, ra, ri);
        op(0, 0, 8'h80, '0, rd); check("R10 one push no overflow", rd, 64'h0);
        op(1, 1, 8'h98, 64'h3, rd);
        dual(1, 0, 8'hA8, '0, 1, 0, 8'hA8, '0, ra, ri);
        check("R10 same pop data", ra, ri);
        check("R10 ap entry", ra[31:0], 32'h1);
        op(0, 0, 8'hA8, '0, rd); check("R10 single pop", rd[31:0], 32'h3);
        dual(1, 1, 8'h48, 64'h3, 1, 1, 8'h48, 64'hC, ra, ri);
        op(1, 0, 8'h48, '0, rd); check("R10 enable priority", rd, 64'h3);

        // R11: ignored accesses
        op(0, 1, 8'h78, 64'h1234, rd);
        op(0, 1, 8'h58, 64'hFFFF, rd);
        op(1, 0, 8'h60, '0, rd); check("R11 send reads zero", rd, 64'd0);
        op(1, 0, 8'h58, '0, rd); check("R11 unmapped zero", rd, 64'd0);
        op(1, 0, 8'h50, '0, rd); check("R11 no state change", rd, 64'h0000_0000_0002_0000);

        // Random mix against the model
        for (int n = 0; n < 4000; n++) begin
            int  sel;
            sel = int'($urandom % 10);
            if (sel < 2) begin
                dual(1, 1'($urandom), pick_addr(int'($urandom % 14)), {$urandom, $urandom},
                     1, 1'($urandom), pick_addr(int'($urandom % 14)), {$urandom, $urandom}, ra, ri);
            end else begin
                op(1'($urandom), 1'($urandom), pick_addr(int'($urandom % 14)),
                   {$urandom, $urandom}, rd);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule